// File: doc/BRIEF.md
# Segmented Program and Data Address Generator

This block produces the instruction-fetch address and the load/store address for a small 16-bit pipelined RISC core whose memories are addressed through 4-bit segments. It keeps a 12-bit program counter and two segment registers, one for code and one for data. Each address is a segment in the upper bits placed in front of a 12-bit offset in the lower bits.

The fetch address is the code segment followed by the program counter. The counter steps by one on every fetch cycle and wraps inside its 12-bit window; it never carries into the segment. A branch redirect comes in two forms. A near branch replaces only the counter with the low 12 bits of a branch register and leaves the code segment alone. A far branch takes all 16 bits, so the code segment is reloaded from the register's top bits.

The load/store address is the data segment followed by the offset field of the memory instruction. Either segment register can be written from a general register. A mode flag chooses where loads and stores go: data memory when the flag is 0, instruction memory when it is 1. The decoder pulses a toggle input to flip the flag when it sees the instruction reserved for that purpose. The core has no branch interlock, so this block never drops the fetches that follow a redirect.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous reset clears the program counter, both segment registers and the mode flag. After reset, `fetch_addr` is 0, the upper `SEG_W` bits of `ls_addr` are 0 and `ls_to_imem` is 0.
- R2: `fetch_addr` equals {code segment, program counter}. When `fetch_en` is 1 and `br_req` is 0, the counter field of `fetch_addr` is one greater after the next clock edge.
- R3: When the counter field is all ones, an increment wraps it to 0 and leaves the code segment field of `fetch_addr` unchanged.
- R4: When `fetch_en` and `br_req` are both 0, `fetch_addr` holds its value.
- R5: A near branch (`br_req`=1, `br_far`=0) loads the counter field with `br_target[OFF_W-1:0]` at the next edge. The code segment field is unchanged.
- R6: A far branch (`br_req`=1, `br_far`=1) makes `fetch_addr` equal to `br_target` after the next edge. The code segment becomes the upper `SEG_W` bits of `br_target`.
- R7: A branch request takes priority over `fetch_en` when both are asserted in the same cycle.
- R8: The cycles after a branch are not squashed. With `fetch_en` held at 1, the counter field continues from the branch target in steps of one.
- R9: `seg_wr_en`=1 loads the low `SEG_W` bits of `seg_wr_val` at the next edge. It loads the code segment when `seg_wr_sel`=0 and the data segment when `seg_wr_sel`=1. The other segment does not change.
- R10: `ls_addr` equals {data segment, `ls_offset`} in the same cycle, with no register on the offset path (default `LS_ADDR_REG`=0).
- R11: A pulse on `mode_toggle` inverts `ls_to_imem` at the next edge and has no effect on `fetch_addr` beyond its normal increment or hold.
- R12: A far branch and a code-segment write in the same cycle leave the code segment equal to the far branch's upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Fetch cycle: advance the program counter |
| br_req | input | 1 | Branch redirect request |
| br_far | input | 1 | 1 = far branch (reload code segment), 0 = near branch |
| br_target | input | SEG_W+OFF_W | Contents of the branch register |
| seg_wr_en | input | 1 | Write a segment register |
| seg_wr_sel | input | 1 | 0 = code segment, 1 = data segment |
| seg_wr_val | input | SEG_W+OFF_W | General register value; low SEG_W bits are used |
| mode_toggle | input | 1 | Invert the memory-select flag |
| ls_offset | input | OFF_W | Offset field of the load/store instruction |
| fetch_addr | output | SEG_W+OFF_W | Instruction fetch address |
| ls_addr | output | SEG_W+OFF_W | Load/store address |
| ls_to_imem | output | 1 | 1 = loads and stores go to instruction memory |

## Verification
The bench builds the block with `SEG_W`=2 and `OFF_W`=4, which gives a 6-bit address space. In that space the bench can drive every branch target in both near and far form, write every segment value to both registers, and combine every load/store offset with several data segments. The 4-bit counter wraps every sixteen fetches, so the bench crosses the wrap point several times during its increment runs and again after branches. The bench also exercises the cases where two inputs meet in one cycle: branch with increment, far branch with code-segment write, and mode toggle with other traffic.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   typedef enum logic {
      SEG_CODE = 1'b0,
      SEG_DATA = 1'b1
   } seg_sel_e;

   localparam int unsigned SEG_COUNT = 2;
endpackage

// File: rtl/addr_pc_unit.sv
module addr_pc_unit #(
   parameter int unsigned OFF_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             load,
   input  logic [OFF_W-1:0] load_val,
   output logic [OFF_W-1:0] pc
);
   localparam logic [OFF_W-1:0] STEP = OFF_W'(1);

   logic [OFF_W-1:0] pc_q;
   logic [OFF_W-1:0] pc_d;

   // a redirect outranks the sequential step; the step wraps in the offset space
   always_comb begin
      pc_d = pc_q;
      if (load) begin
         pc_d = load_val;
      end else if (adv) begin
         pc_d = pc_q + STEP;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_d;
      end
   end

   assign pc = pc_q;
endmodule

// File: rtl/addr_seg_bank.sv
module addr_seg_bank
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W  = 4,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              far_load,
   input  logic [SEG_W-1:0]  far_seg,
   input  logic              wr_en,
   input  seg_sel_e          wr_sel,
   input  logic [ADDR_W-1:0] wr_val,
   output logic [SEG_W-1:0]  code_seg,
   output logic [SEG_W-1:0]  data_seg
);
   logic [SEG_W-1:0] seg_q [SEG_COUNT];

   for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_seg
      logic             sel_hit;
      logic             far_hit;
      logic [SEG_W-1:0] nxt;

      assign sel_hit = wr_en && (wr_sel == seg_sel_e'(gi));
      // only the code segment listens to far branches
      assign far_hit = far_load && (gi == int'(SEG_CODE));

      always_comb begin
         nxt = seg_q[gi];
         if (far_hit) begin
            nxt = far_seg;
         end else if (sel_hit) begin
            nxt = wr_val[SEG_W-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            seg_q[gi] <= '0;
         end else begin
            seg_q[gi] <= nxt;
         end
      end
   end

   assign code_seg = seg_q[int'(SEG_CODE)];
   assign data_seg = seg_q[int'(SEG_DATA)];
endmodule

// File: rtl/addr_mode_flag.sv
module addr_mode_flag (
   input  logic clk,
   input  logic rst,
   input  logic toggle,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
      end else if (toggle) begin
         flag_q <= ~flag_q;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W       = 4,
   parameter int unsigned OFF_W       = 12,
   parameter bit          LS_ADDR_REG = 1'b0,
   localparam int unsigned ADDR_W     = SEG_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_en,
   input  logic              br_req,
   input  logic              br_far,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              seg_wr_en,
   input  logic              seg_wr_sel,
   input  logic [ADDR_W-1:0] seg_wr_val,
   input  logic              mode_toggle,
   input  logic [OFF_W-1:0]  ls_offset,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] ls_addr,
   output logic              ls_to_imem
);
   if (SEG_W < 1) begin : g_bad_seg
      $error("seg_addr_gen: SEG_W must be at least 1");
   end
   if (OFF_W < 2) begin : g_bad_off
      $error("seg_addr_gen: OFF_W must be at least 2");
   end

   logic [OFF_W-1:0] pc;
   logic [SEG_W-1:0] code_seg;
   logic [SEG_W-1:0] data_seg;
   logic             far_load;

   assign far_load = br_req && br_far;

   addr_pc_unit #(.OFF_W(OFF_W)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .adv      (fetch_en),
      .load     (br_req),
      .load_val (br_target[OFF_W-1:0]),
      .pc       (pc)
   );

   addr_seg_bank #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_seg (
      .clk      (clk),
      .rst      (rst),
      .far_load (far_load),
      .far_seg  (br_target[ADDR_W-1:OFF_W]),
      .wr_en    (seg_wr_en),
      .wr_sel   (seg_sel_e'(seg_wr_sel)),
      .wr_val   (seg_wr_val),
      .code_seg (code_seg),
      .data_seg (data_seg)
   );

   addr_mode_flag u_mode (
      .clk    (clk),
      .rst    (rst),
      .toggle (mode_toggle),
      .flag   (ls_to_imem)
   );

   assign fetch_addr = {code_seg, pc};

   if (LS_ADDR_REG) begin : g_ls_reg
      logic [ADDR_W-1:0] ls_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            ls_q <= '0;
         end else begin
            ls_q <= {data_seg, ls_offset};
         end
      end
      assign ls_addr = ls_q;
   end else begin : g_ls_comb
      assign ls_addr = {data_seg, ls_offset};
   end
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
   parameter int unsigned SEG_W       = 4,
   parameter int unsigned OFF_W       = 12,
   parameter bit          LS_ADDR_REG = 1'b0,
   localparam int unsigned ADDR_W     = SEG_W + OFF_W
) (
   input logic              clk,
   input logic              rst,
   input logic              fetch_en,
   input logic              br_req,
   input logic              br_far,
   input logic [ADDR_W-1:0] br_target,
   input logic              seg_wr_en,
   input logic              seg_wr_sel,
   input logic [ADDR_W-1:0] seg_wr_val,
   input logic              mode_toggle,
   input logic [OFF_W-1:0]  ls_offset,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic [ADDR_W-1:0] ls_addr,
   input logic              ls_to_imem
);
   logic code_wr;
   assign code_wr = seg_wr_en && !seg_wr_sel;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (fetch_addr == '0) && !ls_to_imem); // R1

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && !br_req) |=>
         fetch_addr[OFF_W-1:0] == OFF_W'($past(fetch_addr[OFF_W-1:0]) + OFF_W'(1))); // R2

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!fetch_en && !br_req && !code_wr) |=> $stable(fetch_addr)); // R4

   AST_NEAR_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (br_req && !br_far && !code_wr) |=>
         (fetch_addr[OFF_W-1:0] == $past(br_target[OFF_W-1:0])) &&
         $stable(fetch_addr[ADDR_W-1:OFF_W])); // R5

   AST_FAR_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (br_req && br_far) |=> fetch_addr == $past(br_target)); // R12

   AST_MODE_FLIP: assert property (@(posedge clk) disable iff (rst)
      mode_toggle |=> ls_to_imem != $past(ls_to_imem)); // R11

   AST_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
      !mode_toggle |=> $stable(ls_to_imem)); // R11

   if (!LS_ADDR_REG) begin : g_ls_chk
      AST_DSEG_HOLD: assert property (@(posedge clk) disable iff (rst)
         !(seg_wr_en && seg_wr_sel) |=> $stable(ls_addr[ADDR_W-1:OFF_W])); // R9

      AST_LS_OFFSET: assert property (@(posedge clk) disable iff (rst)
         ls_addr[OFF_W-1:0] == ls_offset); // R10
   end
endmodule

bind seg_addr_gen seg_addr_chk #(
   .SEG_W       (SEG_W),
   .OFF_W       (OFF_W),
   .LS_ADDR_REG (LS_ADDR_REG)
) u_seg_addr_chk (
   .clk         (clk),
   .rst         (rst),
   .fetch_en    (fetch_en),
   .br_req      (br_req),
   .br_far      (br_far),
   .br_target   (br_target),
   .seg_wr_en   (seg_wr_en),
   .seg_wr_sel  (seg_wr_sel),
   .seg_wr_val  (seg_wr_val),
   .mode_toggle (mode_toggle),
   .ls_offset   (ls_offset),
   .fetch_addr  (fetch_addr),
   .ls_addr     (ls_addr),
   .ls_to_imem  (ls_to_imem)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;
   localparam int unsigned SW = 2;
   localparam int unsigned OW = 4;
   localparam int unsigned AW = SW + OW;
   localparam int unsigned OMASK = (1 << OW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          fetch_en = 1'b0;
   logic          br_req = 1'b0;
   logic          br_far = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic          seg_wr_en = 1'b0;
   logic          seg_wr_sel = 1'b0;
   logic [AW-1:0] seg_wr_val = '0;
   logic          mode_toggle = 1'b0;
   logic [OW-1:0] ls_offset = '0;
   logic [AW-1:0] fetch_addr;
   logic [AW-1:0] ls_addr;
   logic          ls_to_imem;

   int checks = 0;
   int errors = 0;
   int m_pc = 0, m_cs = 0, m_ds = 0, m_flag = 0;

   always #2 clk = ~clk;

   seg_addr_gen #(.SEG_W(SW), .OFF_W(OW)) i_seg_addr_gen (
      .clk (clk), .rst (rst), .fetch_en (fetch_en), .br_req (br_req),
      .br_far (br_far), .br_target (br_target), .seg_wr_en (seg_wr_en),
      .seg_wr_sel (seg_wr_sel), .seg_wr_val (seg_wr_val),
      .mode_toggle (mode_toggle), .ls_offset (ls_offset),
      .fetch_addr (fetch_addr), .ls_addr (ls_addr), .ls_to_imem (ls_to_imem)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, int'(fetch_addr), (m_cs << OW) | m_pc);
      check(tag, int'(ls_addr), (m_ds << OW) | int'(ls_offset));
      check(tag, int'(ls_to_imem), m_flag);
   endtask

   // applies the driven inputs to the model, clocks once, compares
   task automatic tick(string tag);
      if (br_req) begin
         m_pc = int'(br_target) & OMASK;
         if (br_far) m_cs = int'(br_target) >> OW;
      end else if (fetch_en) begin
         m_pc = (m_pc + 1) & OMASK;
      end
      if (seg_wr_en) begin
         if (seg_wr_sel) m_ds = int'(seg_wr_val) & ((1 << SW) - 1);
         else if (!(br_req && br_far)) m_cs = int'(seg_wr_val) & ((1 << SW) - 1);
      end
      if (mode_toggle) m_flag ^= 1;
      @(posedge clk);
      #1;
      compare_all(tag);
   endtask

   task automatic idle();
      fetch_en = 0; br_req = 0; br_far = 0; seg_wr_en = 0; mode_toggle = 0;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 0;
      compare_all("R1");

      // R2 / R3: long increment run crossing the wrap several times
      fetch_en = 1;
      for (int i = 0; i < 40; i++) begin
         tick(m_pc == OMASK ? "R3" : "R2");
      end

      // R4: hold
      idle();
      for (int i = 0; i < 4; i++) tick("R4");

      // R9: every value to both segment registers
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < (1 << AW); v++) begin
            seg_wr_en = 1; seg_wr_sel = s[0]; seg_wr_val = AW'(v);
            tick("R9");
         end
      end
      idle();

      // R10: offset sweep under each data segment
      for (int d = 0; d < (1 << SW); d++) begin
         seg_wr_en = 1; seg_wr_sel = 1; seg_wr_val = AW'(d);
         tick("R9");
         seg_wr_en = 0;
         for (int o = 0; o <= int'(OMASK); o++) begin
            ls_offset = OW'(o);
            #1;
            check("R10", int'(ls_addr), (d << OW) | o);
         end
      end

      // R5 + R7: near branch sweep with fetch_en also high
      fetch_en = 1;
      for (int t = 0; t < (1 << AW); t++) begin
         br_req = 1; br_far = 0; br_target = AW'(t);
         tick("R5");
         check("R7", int'(fetch_addr) & OMASK, t & OMASK);
      end

      // R6: far branch sweep, then R8 continuation
      for (int t = 0; t < (1 << AW); t++) begin
         br_req = 1; br_far = 1; br_target = AW'(t);
         tick("R6");
         check("R6", int'(fetch_addr), t);
         br_req = 0;
         tick("R8");
         tick("R8");
      end

      // R11: toggles interleaved with fetch
      br_req = 0;
      for (int i = 0; i < 6; i++) begin
         mode_toggle = i[0];
         tick("R11");
      end
      mode_toggle = 1; fetch_en = 0;
      tick("R11");
      mode_toggle = 0;
      tick("R11");

      // R12: far branch and code-segment write collide
      for (int v = 0; v < (1 << SW); v++) begin
         br_req = 1; br_far = 1; br_target = AW'((((v + 1) & 3) << OW) | 5);
         seg_wr_en = 1; seg_wr_sel = 0; seg_wr_val = AW'(v);
         tick("R12");
         check("R12", int'(fetch_addr) >> OW, (v + 1) & 3);
      end
      idle();
      tick("R4");

      // R1: reset again after traffic
      mode_toggle = 1; tick("R11"); mode_toggle = 0;
      rst = 1;
      @(posedge clk); #1;
      rst = 0;
      m_pc = 0; m_cs = 0; m_ds = 0; m_flag = 0;
      compare_all("R1");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule